// File: doc/BRIEF.md
# Status and Control Flag Unit

This block keeps the 16-bit condition and control word of a processor core. Each cycle the ALU can present one operation: the two operand values, the result it produced, the raw carry-out of its adder, and a class code that says what kind of operation it was. The unit derives the six condition flags: carry, parity, auxiliary (nibble) carry, zero, sign and overflow. It then updates only the flags that this class of operation may touch.

Compares are judged on the operands alone. The unit forms the difference itself and ignores whatever the ALU placed on its result and carry lines. Moves and jumps are transparent to the flag word. The three control flags (single-step trap, interrupt enable, string direction) change only through an explicit set/clear command. The direction flag is also brought out on its own pin for the index-stepping logic. A high direction means the index registers decrement.

All state is held in registers with a synchronous active-high reset. An operation presented with `op_valid` high at a rising edge is visible on `flags_o` right after that edge.

Top module: `flag_status_unit`

## Requirements
- R1: While reset is high at a clock edge, the flag word becomes 16'h0002 and `dir_dec_o` becomes 0.
- R2: Add (op_class 0, op_sub 0): carry at bit 0 takes `alu_cout`. Auxiliary carry at bit 4 is the carry into result bit 4 (a[4]^b[4]^res[4]). Overflow at bit 11 is set when both operands share a sign that the result does not.
- R3: Subtract (op_class 0, op_sub 1), where `alu_cout` is the adder carry of a+~b+1: carry at bit 0 is the borrow, equal to the inverse of `alu_cout`. Auxiliary carry is a[4]^b[4]^res[4]. Overflow is set when the operand signs differ and the result sign differs from operand a.
- R4: For arithmetic, compare and logic operations, parity at bit 2 is 1 when bits 7:0 of the result hold an even number of ones, including none, and 0 otherwise.
- R5: For arithmetic, compare and logic operations, zero at bit 6 is set exactly when the whole result is 0, and sign at bit 7 copies the result's top bit.
- R6: Compare (op_class 2) sets all six condition flags as a subtract of `opnd_b` from `opnd_a` would. `alu_res`, `alu_cout` and `op_sub` have no effect.
- R7: Logic (op_class 1) clears carry and overflow, keeps auxiliary carry, and sets parity, zero and sign from `alu_res`.
- R8: Move (op_class 3), jump (op_class 4), the unused codes 6 and 7, and any cycle with `op_valid` low leave the whole flag word unchanged.
- R9: Flag control (op_class 5) writes `ctl_set` into the flag picked by `ctl_sel`: 0 trap (bit 8), 1 interrupt enable (bit 9), 2 direction (bit 10). Selector 3 writes nothing, and no other bit changes.
- R10: Arithmetic, compare and logic operations never change bits 10:8.
- R11: `dir_dec_o` always equals direction bit 10 of the flag word.
- R12: Bit 1 always reads 1. Bits 3, 5 and 15:12 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_class | input | 3 | Operation class code (see R2 to R9) |
| op_sub | input | 1 | Arithmetic class: 1 for subtract, 0 for add |
| opnd_a | input | W | First ALU operand |
| opnd_b | input | W | Second ALU operand |
| alu_res | input | W | ALU result |
| alu_cout | input | 1 | Raw carry-out of the ALU adder |
| ctl_sel | input | 2 | Control flag selector for flag-control operations |
| ctl_set | input | 1 | Value written to the selected control flag |
| flags_o | output | 16 | Full flag word |
| dir_dec_o | output | 1 | Index step direction, 1 = decrement |

## Verification
Two functions share the flag word and can act on it in back-to-back cycles: condition-flag updates from arithmetic, compare and logic, and control-flag writes. The random stream interleaves all classes, so a direction or interrupt write lands right beside an add or compare. After each edge the bench compares the full 16-bit word with its model, which shows whether either path disturbed the other's bits. Compares are driven with deliberately wrong `alu_res` and `alu_cout`, so any leakage of the ALU lines into compare flags is caught.

// File: rtl/flagu_pkg.sv
package flagu_pkg;

  // operation classes
  localparam logic [2:0] CLS_ARITH = 3'd0;
  localparam logic [2:0] CLS_LOGIC = 3'd1;
  localparam logic [2:0] CLS_CMP   = 3'd2;
  localparam logic [2:0] CLS_MOVE  = 3'd3;
  localparam logic [2:0] CLS_JUMP  = 3'd4;
  localparam logic [2:0] CLS_FCTL  = 3'd5;

  // flag word bit positions
  localparam int FB_CF = 0;
  localparam int FB_PF = 2;
  localparam int FB_AF = 4;
  localparam int FB_ZF = 6;
  localparam int FB_SF = 7;
  localparam int FB_TF = 8;
  localparam int FB_IF = 9;
  localparam int FB_DF = 10;
  localparam int FB_OF = 11;

  localparam int          FLAG_W     = 16;
  localparam int          NUM_CTL    = 3;
  localparam logic [15:0] FIXED_ONES = 16'h0002;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } cond_flags_t;

  localparam cond_flags_t COND_RESET = '0;

endpackage

// File: rtl/flagu_cond_calc.sv
module flagu_cond_calc
  import flagu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] res,
  input  logic         cout,
  input  logic         is_sub,
  output cond_flags_t  cond
);
  localparam int MSB    = W - 1;
  localparam int PAR_W  = 8;
  localparam int NIB_HI = 4;

  logic sign_a, sign_b, sign_r;

  always_comb begin
    sign_a  = a[MSB];
    sign_b  = b[MSB];
    sign_r  = res[MSB];
    cond.cf = is_sub ? ~cout : cout;
    cond.pf = ~(^res[PAR_W-1:0]);
    cond.af = a[NIB_HI] ^ b[NIB_HI] ^ res[NIB_HI];
    cond.zf = (res == '0);
    cond.sf = sign_r;
    if (is_sub) cond.of = (sign_a != sign_b) && (sign_r != sign_a);
    else        cond.of = (sign_a == sign_b) && (sign_r != sign_a);
  end

endmodule

// File: rtl/flagu_ctrl_reg.sv
module flagu_ctrl_reg
  import flagu_pkg::*;
#(
  parameter int N = NUM_CTL
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   sel,
  input  logic         val,
  output logic [N-1:0] ctl_q
);
  for (genvar i = 0; i < N; i++) begin : g_ctl
    always_ff @(posedge clk) begin
      if (rst)                             ctl_q[i] <= 1'b0;
      else if (wr_en && (sel == 2'(i)))    ctl_q[i] <= val;
    end
  end

endmodule

// File: rtl/flag_status_unit.sv
module flag_status_unit
  import flagu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [2:0]   op_class,
  input  logic         op_sub,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [W-1:0] alu_res,
  input  logic         alu_cout,
  input  logic [1:0]   ctl_sel,
  input  logic         ctl_set,
  output logic [15:0]  flags_o,
  output logic         dir_dec_o
);
  localparam logic [15:0] COND_MASK = 16'h08D5;
  localparam logic [15:0] CTL_MASK  = 16'h0700;

  logic         is_arith, is_logic, is_cmp, is_fctl;
  logic [W-1:0] cmp_diff;
  logic         cmp_borrow;
  logic [W-1:0] calc_res;
  logic         calc_cout;
  logic         calc_sub;
  cond_flags_t  calc_flags;
  cond_flags_t  cond_q;
  logic [NUM_CTL-1:0] ctl_q;

  assign is_arith = op_valid && (op_class == CLS_ARITH);
  assign is_logic = op_valid && (op_class == CLS_LOGIC);
  assign is_cmp   = op_valid && (op_class == CLS_CMP);
  assign is_fctl  = op_valid && (op_class == CLS_FCTL);

  // compare: the unit forms its own difference and adder carry
  assign {cmp_borrow, cmp_diff} = {1'b0, opnd_a} - {1'b0, opnd_b};

  always_comb begin
    calc_res  = is_cmp ? cmp_diff    : alu_res;
    calc_cout = is_cmp ? ~cmp_borrow : alu_cout;
    calc_sub  = is_cmp | op_sub;
  end

  flagu_cond_calc #(.W(W)) u_calc (
    .a      (opnd_a),
    .b      (opnd_b),
    .res    (calc_res),
    .cout   (calc_cout),
    .is_sub (calc_sub),
    .cond   (calc_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= COND_RESET;
    end else if (is_arith || is_cmp) begin
      cond_q <= calc_flags;
    end else if (is_logic) begin
      cond_q.cf <= 1'b0;
      cond_q.of <= 1'b0;
      cond_q.pf <= calc_flags.pf;
      cond_q.zf <= calc_flags.zf;
      cond_q.sf <= calc_flags.sf;
    end
  end

  flagu_ctrl_reg #(.N(NUM_CTL)) u_ctl (
    .clk   (clk),
    .rst   (rst),
    .wr_en (is_fctl),
    .sel   (ctl_sel),
    .val   (ctl_set),
    .ctl_q (ctl_q)
  );

  always_comb begin
    flags_o        = FIXED_ONES;
    flags_o[FB_CF] = cond_q.cf;
    flags_o[FB_PF] = cond_q.pf;
    flags_o[FB_AF] = cond_q.af;
    flags_o[FB_ZF] = cond_q.zf;
    flags_o[FB_SF] = cond_q.sf;
    flags_o[FB_OF] = cond_q.of;
    flags_o[FB_TF] = ctl_q[0];
    flags_o[FB_IF] = ctl_q[1];
    flags_o[FB_DF] = ctl_q[2];
    dir_dec_o      = ctl_q[2];
  end

  // R8: moves and jumps are transparent
  a_r8_move_hold: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_class == CLS_MOVE || op_class == CLS_JUMP)) |=> $stable(flags_o));

  // R7: logic ops clear carry and overflow
  a_r7_logic_clear: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_class == CLS_LOGIC) |=> (!flags_o[FB_CF] && !flags_o[FB_OF]));

  // R9: flag control leaves condition bits alone
  a_r9_fctl_isolated: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_class == CLS_FCTL) |=> $stable(flags_o & COND_MASK));

  // R10: condition updates never touch control bits
  a_r10_ctl_hold: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_class == CLS_ARITH || op_class == CLS_LOGIC || op_class == CLS_CMP))
      |=> $stable(flags_o & CTL_MASK));

  // R5: zero result sets the zero flag
  a_r5_zero_set: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_class == CLS_ARITH || op_class == CLS_LOGIC) && alu_res == '0)
      |=> flags_o[FB_ZF]);

  // R6: equal operands in a compare give zero and no borrow
  a_r6_cmp_equal: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_class == CLS_CMP && opnd_a == opnd_b)
      |=> (flags_o[FB_ZF] && !flags_o[FB_CF]));

endmodule

// File: tb/tb_flag_status_unit.sv
module tb_flag_status_unit;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic         op_valid;
  logic [2:0]   op_class;
  logic         op_sub;
  logic [W-1:0] opnd_a, opnd_b, alu_res;
  logic         alu_cout;
  logic [1:0]   ctl_sel;
  logic         ctl_set;
  logic [15:0]  flags_o;
  logic         dir_dec_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_f;

  always #10 clk = ~clk;

  flag_status_unit #(.W(W)) dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_class(op_class), .op_sub(op_sub),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .alu_res(alu_res), .alu_cout(alu_cout),
    .ctl_sel(ctl_sel), .ctl_set(ctl_set), .flags_o(flags_o), .dir_dec_o(dir_dec_o)
  );

  function automatic logic [15:0] model(input logic [15:0] f, input logic v, input logic [2:0] c,
      input logic s, input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] r,
      input logic co, input logic [1:0] sel, input logic val);
    logic [15:0] n;
    logic [W:0]  t;
    logic        sub;
    n = f;
    if (!v) return n;
    if (c == 3'd2) begin
      t = {1'b0, a} - {1'b0, b};
      r = t[W-1:0];
      co = !t[W];
    end
    sub = (c == 3'd2) || s;
    if (c == 3'd0 || c == 3'd2 || c == 3'd1) begin
      n[2] = ($countones(r[7:0]) % 2) == 0;
      n[6] = (r == 0);
      n[7] = r[W-1];
    end
    if (c == 3'd0 || c == 3'd2) begin
      n[0]  = sub ? !co : co;
      n[4]  = a[4] ^ b[4] ^ r[4];
      n[11] = sub ? (a[W-1] != b[W-1] && r[W-1] != a[W-1])
                  : (a[W-1] == b[W-1] && r[W-1] != a[W-1]);
    end else if (c == 3'd1) begin
      n[0] = 1'b0; n[11] = 1'b0;
    end else if (c == 3'd5 && sel != 2'd3) begin
      n[8 + sel] = val;
    end
    return n;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic v, input logic [2:0] c, input logic s, input logic [W-1:0] a,
      input logic [W-1:0] b, input logic [W-1:0] r, input logic co, input logic [1:0] sel,
      input logic val, input string req);
    @(negedge clk);
    op_valid = v; op_class = c; op_sub = s; opnd_a = a; opnd_b = b;
    alu_res = r; alu_cout = co; ctl_sel = sel; ctl_set = val;
    exp_f = model(exp_f, v, c, s, a, b, r, co, sel, val);
    @(posedge clk); #1;
    check(req, flags_o, exp_f);
    check("R11", {15'd0, dir_dec_o}, {15'd0, exp_f[10]});
    check("R12", flags_o & 16'hF02A, 16'h0002);
  endtask

  // ALU model helpers
  task automatic add_op(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    logic [W:0] t;
    t = {1'b0, a} + {1'b0, b};
    do_op(1'b1, 3'd0, 1'b0, a, b, t[W-1:0], t[W], 2'd0, 1'b0, req);
  endtask

  task automatic sub_op(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    do_op(1'b1, 3'd0, 1'b1, a, b, a - b, (a >= b), 2'd0, 1'b0, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED);
    rst = 1'b1; op_valid = 1'b0; op_class = 3'd0; op_sub = 1'b0;
    opnd_a = '0; opnd_b = '0; alu_res = '0; alu_cout = 1'b0; ctl_sel = 2'd0; ctl_set = 1'b0;
    repeat (3) @(posedge clk); #1;
    exp_f = 16'h0002;
    check("R1", flags_o, 16'h0002);
    check("R1", {15'd0, dir_dec_o}, 16'd0);
    @(negedge clk); rst = 1'b0;

    // directed corners
    add_op(16'h7FFF, 16'h0001, "R2 signed overflow");
    add_op(16'hFFFF, 16'h0001, "R2 carry zero");
    add_op(16'h000F, 16'h0001, "R2 nibble carry");
    sub_op(16'h0000, 16'h0001, "R3 borrow");
    sub_op(16'h8000, 16'h0001, "R3 overflow");
    do_op(1'b1, 3'd1, 1'b0, '0, '0, 16'h0000, 1'b1, 2'd0, 1'b0, "R4 R5 zero parity even");
    do_op(1'b1, 3'd1, 1'b0, '0, '0, 16'hFF07, 1'b1, 2'd0, 1'b0, "R4 odd parity R5 sign");
    do_op(1'b1, 3'd2, 1'b1, 16'h1234, 16'h1234, 16'hFFFF, 1'b0, 2'd0, 1'b0, "R6 equal");
    do_op(1'b1, 3'd2, 1'b0, 16'h0001, 16'h0002, 16'h0000, 1'b1, 2'd0, 1'b0, "R6 less");
    do_op(1'b1, 3'd5, 1'b0, '0, '0, '0, 1'b0, 2'd2, 1'b1, "R9 set direction");
    do_op(1'b1, 3'd5, 1'b0, '0, '0, '0, 1'b0, 2'd1, 1'b1, "R9 set interrupt");
    do_op(1'b1, 3'd5, 1'b0, '0, '0, '0, 1'b0, 2'd3, 1'b1, "R9 selector 3 ignored");
    add_op(16'h4000, 16'h4000, "R10 control kept");
    do_op(1'b1, 3'd3, 1'b0, 16'h0, 16'h0, 16'h0, 1'b1, 2'd0, 1'b0, "R8 move");
    do_op(1'b0, 3'd0, 1'b0, 16'h0, 16'h0, 16'h0, 1'b1, 2'd0, 1'b0, "R8 invalid");
    do_op(1'b1, 3'd5, 1'b0, '0, '0, '0, 1'b0, 2'd2, 1'b0, "R9 clear direction");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0]   c;
      logic [W-1:0] a, b;
      logic         s, v;
      c = 3'($urandom % 8);
      a = W'($urandom); b = W'($urandom);
      if (i % 9 == 0) b = a;
      s = 1'($urandom); v = ($urandom % 8) != 0;
      if (c == 3'd0 && v) begin
        if (s) sub_op(a, b, "R3 random");
        else   add_op(a, b, "R2 random");
      end else begin
        string req;
        case (c)
          3'd1:    req = "R7 random";
          3'd2:    req = "R6 random";
          3'd5:    req = "R9 random";
          default: req = "R8 random";
        endcase
        if (!v) req = "R8 invalid random";
        do_op(v, c, s, a, b, W'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), req);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule